// File: doc/BRIEF.md
# Oversampled Bang-Bang Clock Recovery Loop Controller

This block is the digital loop of a clock and data recovery path. Once per parallel clock cycle it receives a vector of oversampled line samples, several per bit slot. From each slot it takes the sample at the slot centre as the recovered data bit and the first sample of the slot as an edge sample. At every data transition it makes a sign-only early or late decision. The decisions of one cycle are merged into a single vote of +1, -1 or 0.

The vote drives a proportional step of one phase-interpolator code and an integral path that holds a signed frequency word. A wrapping fixed-point accumulator adds that word every cycle, so a steady frequency offset turns into a steady phase slope. A mode machine starts in acquisition, where short runs of votes of the same sign quickly move the frequency word. It enters tracking when a 64-decision window shows a small net imbalance, and there it needs much longer runs before the frequency word moves. A lock flag reports whether the most recent window's net imbalance stayed within a narrower band.

Top module: `cdr_loop_ctrl`

## Requirements
- R1: `data_o[k]` equals sample `samp_i[k*OSR + OSR/2]` of the vector presented one clock edge earlier. Sample index 0 is the oldest in time.
- R2: For slot k the previous bit is the centre sample of slot k-1, or for k=0 the last data bit of the previous cycle. A transition occurs when the previous bit and the centre sample differ. At a transition, an edge sample `samp_i[k*OSR]` equal to the new bit is a late decision, and one that differs is an early decision. The cycle vote is +1 if late decisions outnumber early ones, -1 if early decisions outnumber late ones, and 0 otherwise.
- R3: A cycle with vote 0 (no transition, or a tie) makes no decision. The frequency word, the run state, the window, the mode and the lock flag keep their values, and the phase moves by the frequency word alone.
- R4: A 10-bit accumulator adds vote*16 plus the sign-extended frequency word on each update. `phase_o` is its upper 6 bits and is due two edges after the samples.
- R5: Consecutive nonzero votes of equal sign form a run. When the run reaches 4 (acquisition) or 16 (tracking), the frequency word steps by that sign and the run restarts at zero. A vote of the opposite sign restarts the run at one.
- R6: Every 64 nonzero votes close a window. At the close, `track_o` becomes 1 if the absolute net vote sum of that window is at most 8, and 0 otherwise.
- R7: At a window close, `lock_o` becomes 1 if the absolute net sum is at most 4, and 0 otherwise. It holds between closes.
- R8: Synchronous active-high reset clears the phase, the frequency word, the run, the window, the data, the lock flag, and the mode to acquisition (`track_o`=0).
- R9: The frequency word saturates at +15 and -16 and never wraps.
- R10: The phase code wraps modulo 64 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | BITS*OSR (16) | Oversampled line samples for this cycle, index 0 oldest |
| data_o | output | BITS (4) | Recovered centre-sample bits |
| phase_o | output | PW (6) | Phase-interpolator code |
| freq_o | output | FW (5) | Signed frequency word |
| track_o | output | 1 | 1 = phase tracking, 0 = frequency acquisition |
| lock_o | output | 1 | Net imbalance of the last window within the lock band |

## Verification
The recovered data bits are due one edge after their samples. The phase, the frequency word, the mode and the lock flag are due one edge later, because the registered vote sits between the sampler logic and the loop state. The bench drives each sample vector before an edge and samples all outputs shortly after that edge. It then advances a reference model by one step, applying the vote it held back from the previous step, so each comparison lines up with those two latencies. Directed streams of pure late, pure early, alternating and transition-free vectors force saturation, phase wrap, mode change and lock. Seeded random vectors cover tie and mixed-vote cases.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // signed per-cycle decision: +1 late, -1 early, 0 none
  typedef logic signed [1:0] vote_t;
  localparam vote_t VOTE_UP   = 2'sb01;
  localparam vote_t VOTE_DOWN = 2'sb11;
  localparam vote_t VOTE_NONE = 2'sb00;
endpackage

// File: rtl/cdr_bbpd.sv
module cdr_bbpd
  import cdr_pkg::*;
#(
  parameter int BITS = 4,
  parameter int OSR  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BITS*OSR-1:0]  samp_i,
  output logic [BITS-1:0]      data_q,
  output vote_t                vote_q
);
  localparam int CTR_OFS = OSR / 2;
  localparam int CW      = $clog2(BITS + 1);

  logic            last_q;
  logic [BITS-1:0] ctr, edg, prv, is_late, is_early;
  logic [CW-1:0]   n_late, n_early;
  vote_t           vote_d;

  // slot taps: centre sample is data, first sample of the slot is the edge
  for (genvar k = 0; k < BITS; k++) begin : g_slot
    assign ctr[k] = samp_i[k*OSR + CTR_OFS];
    assign edg[k] = samp_i[k*OSR];
    if (k == 0) begin : g_first
      assign prv[k] = last_q;
    end else begin : g_rest
      assign prv[k] = ctr[k-1];
    end
    assign is_late[k]  = (prv[k] != ctr[k]) && (edg[k] == ctr[k]);
    assign is_early[k] = (prv[k] != ctr[k]) && (edg[k] != ctr[k]);
  end

  always_comb begin
    n_late  = '0;
    n_early = '0;
    for (int k = 0; k < BITS; k++) begin
      n_late  = n_late  + CW'(is_late[k]);
      n_early = n_early + CW'(is_early[k]);
    end
    if (n_late > n_early)      vote_d = VOTE_UP;
    else if (n_early > n_late) vote_d = VOTE_DOWN;
    else                       vote_d = VOTE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vote_q <= VOTE_NONE;
      last_q <= 1'b0;
    end else begin
      data_q <= ctr;
      vote_q <= vote_d;
      last_q <= ctr[BITS-1];
    end
  end

  AST_VOTE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    vote_q != 2'sb10); // R2
endmodule

// File: rtl/cdr_integ.sv
module cdr_integ
  import cdr_pkg::*;
#(
  parameter int FW      = 5,
  parameter int ACQ_RUN = 4,
  parameter int TRK_RUN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  vote_t                vote,
  input  logic                 track,
  output logic signed [FW-1:0] freq_q
);
  localparam int RUN_MAX = (TRK_RUN > ACQ_RUN) ? TRK_RUN : ACQ_RUN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic signed [FW-1:0] FMAX = {1'b0, {(FW-1){1'b1}}};
  localparam logic signed [FW-1:0] FMIN = {1'b1, {(FW-1){1'b0}}};

  logic [RUN_W-1:0] run_q, run_inc, thr;
  logic             pos_q, same, hit, up;

  always_comb begin
    up      = (vote == VOTE_UP);
    same    = (run_q != '0) && (pos_q == up);
    run_inc = same ? run_q + RUN_W'(1) : RUN_W'(1);
    thr     = track ? RUN_W'(TRK_RUN) : RUN_W'(ACQ_RUN);
    hit     = (run_inc >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      pos_q  <= 1'b0;
      freq_q <= '0;
    end else if (vote != VOTE_NONE) begin
      pos_q <= up;
      if (hit) begin
        run_q <= '0;
        if (up && freq_q != FMAX)       freq_q <= freq_q + FW'(1);
        else if (!up && freq_q != FMIN) freq_q <= freq_q - FW'(1);
      end else begin
        run_q <= run_inc;
      end
    end
  end

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vote == VOTE_NONE) |=> $stable(freq_q)); // R3
  AST_FREQ_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (freq_q == $past(freq_q) || freq_q == $past(freq_q) + FW'(1)
              || freq_q == $past(freq_q) - FW'(1))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (freq_q == FMAX) |=> (freq_q != FMIN)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (freq_q == FMIN) |=> (freq_q != FMAX)); // R9
endmodule

// File: rtl/cdr_window.sv
module cdr_window
  import cdr_pkg::*;
#(
  parameter int WIN      = 64,
  parameter int LOCK_TOL = 4,
  parameter int TRK_TOL  = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  vote_t vote,
  output logic  track_q,
  output logic  lock_q
);
  localparam int CW = $clog2(WIN);
  localparam int NW = $clog2(WIN) + 2;

  logic [CW-1:0]        cnt_q;
  logic signed [NW-1:0] net_q, net_nx;
  logic [NW-1:0]        absn;
  logic                 done;

  always_comb begin
    net_nx = net_q + {{(NW-2){vote[1]}}, vote};
    absn   = net_nx[NW-1] ? -net_nx : net_nx;
    done   = (vote != VOTE_NONE) && (cnt_q == CW'(WIN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      net_q   <= '0;
      track_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (vote != VOTE_NONE) begin
      if (done) begin
        cnt_q   <= '0;
        net_q   <= '0;
        track_q <= (absn <= NW'(TRK_TOL));
        lock_q  <= (absn <= NW'(LOCK_TOL));
      end else begin
        cnt_q <= cnt_q + CW'(1);
        net_q <= net_nx;
      end
    end
  end

  AST_MODE_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(track_q) |-> $past(done)); // R6
  AST_LOCK_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_q) |-> $past(done)); // R7
endmodule

// File: rtl/cdr_phase_accum.sv
module cdr_phase_accum
  import cdr_pkg::*;
#(
  parameter int PW   = 6,
  parameter int FRAC = 4,
  parameter int FW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  vote_t                vote,
  input  logic signed [FW-1:0] freq,
  output logic [PW-1:0]        phase
);
  localparam int AW = PW + FRAC;

  logic [AW-1:0] acc_q, vstep, fstep;

  always_comb begin
    vstep = AW'({{(AW-2){vote[1]}}, vote} << FRAC);
    fstep = {{(AW-FW){freq[FW-1]}}, freq};
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + vstep + fstep;
  end

  assign phase = acc_q[AW-1:FRAC];

  AST_PHASE_SLEW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (PW'(phase - $past(phase)) inside
              {PW'(0), PW'(1), PW'(2), PW'(-1), PW'(-2)})); // R4
endmodule

// File: rtl/cdr_loop_ctrl.sv
module cdr_loop_ctrl
  import cdr_pkg::*;
#(
  parameter int BITS     = 4,
  parameter int OSR      = 4,
  parameter int PW       = 6,
  parameter int FRAC     = 4,
  parameter int FW       = 5,
  parameter int ACQ_RUN  = 4,
  parameter int TRK_RUN  = 16,
  parameter int WIN      = 64,
  parameter int LOCK_TOL = 4,
  parameter int TRK_TOL  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BITS*OSR-1:0]  samp_i,
  output logic [BITS-1:0]      data_o,
  output logic [PW-1:0]        phase_o,
  output logic signed [FW-1:0] freq_o,
  output logic                 track_o,
  output logic                 lock_o
);
  vote_t vote;

  cdr_bbpd #(.BITS(BITS), .OSR(OSR)) u_pd (
    .clk(clk), .rst(rst), .samp_i(samp_i), .data_q(data_o), .vote_q(vote));

  cdr_integ #(.FW(FW), .ACQ_RUN(ACQ_RUN), .TRK_RUN(TRK_RUN)) u_integ (
    .clk(clk), .rst(rst), .vote(vote), .track(track_o), .freq_q(freq_o));

  cdr_window #(.WIN(WIN), .LOCK_TOL(LOCK_TOL), .TRK_TOL(TRK_TOL)) u_win (
    .clk(clk), .rst(rst), .vote(vote), .track_q(track_o), .lock_q(lock_o));

  cdr_phase_accum #(.PW(PW), .FRAC(FRAC), .FW(FW)) u_ph (
    .clk(clk), .rst(rst), .vote(vote), .freq(freq_o), .phase(phase_o));

  AST_LOCK_IN_TRACK: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> track_o); // R7
  AST_QUIET_MODE: assert property (@(posedge clk) disable iff (rst)
    (vote == VOTE_NONE) |=> ($stable(track_o) && $stable(lock_o))); // R3
endmodule

// File: tb/cdr_loop_ctrl_tb.sv
module cdr_loop_ctrl_tb;
  localparam int BITS = 4, OSR = 4, NS = BITS*OSR;

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] samp_i = '0;
  logic [BITS-1:0] data_o;
  logic [5:0] phase_o;
  logic signed [4:0] freq_o;
  logic track_o, lock_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int m_acc, m_freq, m_run, m_cnt, m_net, pvote;
  bit m_pos, m_trk, m_lock, mprev, wrapped;
  logic [BITS-1:0] mdata;

  always #2.5 clk = ~clk;

  cdr_loop_ctrl u_dut (.clk(clk), .rst(rst), .samp_i(samp_i), .data_o(data_o),
    .phase_o(phase_o), .freq_o(freq_o), .track_o(track_o), .lock_o(lock_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pd_vote(input logic [NS-1:0] s, input bit pb);
    int nl = 0, ne = 0;
    bit p = pb;
    for (int k = 0; k < BITS; k++) begin
      bit c = s[k*OSR + OSR/2];
      bit e = s[k*OSR];
      if (p != c) begin
        if (e == c) nl++; else ne++;
      end
      p = c;
    end
    return (nl > ne) ? 1 : (ne > nl) ? -1 : 0;
  endfunction

  function automatic logic [BITS-1:0] centres(input logic [NS-1:0] s);
    logic [BITS-1:0] d;
    for (int k = 0; k < BITS; k++) d[k] = s[k*OSR + OSR/2];
    return d;
  endfunction

  // clean slots; shifted=1 lets the first sample lag into the previous bit
  function automatic logic [NS-1:0] mk(input logic [BITS-1:0] b, input bit shifted, input bit pb);
    logic [NS-1:0] s;
    for (int k = 0; k < BITS; k++) begin
      for (int j = 0; j < OSR; j++) s[k*OSR + j] = b[k];
      if (shifted) s[k*OSR] = (k == 0) ? pb : b[k-1];
    end
    return s;
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic model_apply(input int v);
    int old = m_acc >> 4;
    m_acc = (m_acc + v*16 + m_freq) & 1023;
    if (old >= 62 && (m_acc >> 4) <= 1) wrapped = 1;
    if (v != 0) begin
      int inc = (m_run != 0 && m_pos == (v > 0)) ? m_run + 1 : 1;
      int thr = m_trk ? 16 : 4;
      int nn  = m_net + v;
      m_pos = (v > 0);
      if (inc >= thr) begin
        m_run = 0;
        m_freq = m_freq + v;
        if (m_freq > 15) m_freq = 15;
        if (m_freq < -16) m_freq = -16;
      end else m_run = inc;
      if (m_cnt == 63) begin
        m_cnt = 0; m_net = 0;
        m_trk = (iabs(nn) <= 8);
        m_lock = (iabs(nn) <= 4);
      end else begin
        m_cnt++; m_net = nn;
      end
    end
  endtask

  task automatic step(input logic [NS-1:0] s);
    @(negedge clk);
    samp_i = s;
    @(posedge clk);
    #1;
    model_apply(pvote);
    pvote = pd_vote(s, mprev);
    mdata = centres(s);
    mprev = mdata[BITS-1];
    chk(data_o == mdata, "R1 data", int'(data_o), int'(mdata));
    chk(int'(phase_o) == (m_acc >> 4), "R4 phase", int'(phase_o), m_acc >> 4);
    chk(int'(freq_o) == m_freq, "R5 freq", int'(freq_o), m_freq);
    chk(track_o == m_trk, "R6 mode", int'(track_o), int'(m_trk));
    chk(lock_o == m_lock, "R7 lock", int'(lock_o), int'(m_lock));
  endtask

  task automatic late_cyc();  step(mk(4'b1010, 1'b0, mprev)); endtask
  task automatic early_cyc(); step(mk(4'b1010, 1'b1, mprev)); endtask
  task automatic quiet_cyc(); step({NS{mprev}}); endtask

  initial begin
    int seed_dummy;
    int f_before, t_before;
    seed_dummy = $urandom(32'd20240611);
    m_acc = 0; m_freq = 0; m_run = 0; m_cnt = 0; m_net = 0; pvote = 0;
    m_pos = 0; m_trk = 0; m_lock = 0; mprev = 0; wrapped = 0;
    repeat (5) @(posedge clk);
    #1;
    // R8 reset state
    chk(phase_o == 6'd0 && freq_o == 5'sd0 && !track_o && !lock_o && data_o == '0,
        "R8 reset", int'({phase_o, freq_o, track_o, lock_o}), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 single late decision advances the phase by one code
    late_cyc(); quiet_cyc();
    chk(phase_o == 6'd1, "R2 late step", int'(phase_o), 1);
    early_cyc(); quiet_cyc();
    chk(phase_o == 6'd0, "R2 early step", int'(phase_o), 0);

    // persistent late votes: acquisition ramps freq to its ceiling
    repeat (200) late_cyc();
    chk(freq_o == 5'sd15, "R9 ceiling", int'(freq_o), 15);
    chk(!track_o, "R6 stay acq", int'(track_o), 0);

    // R3 transition-free cycles make no decision
    f_before = int'(freq_o); t_before = int'(track_o);
    repeat (20) quiet_cyc();
    chk(int'(freq_o) == f_before && int'(track_o) == t_before,
        "R3 quiet hold", int'(freq_o), f_before);

    // balanced votes: windows close with net 0
    for (int i = 0; i < 100; i++) begin late_cyc(); early_cyc(); end
    chk(track_o && lock_o, "R6 R7 enter track+lock", int'({track_o, lock_o}), 3);

    // R5 long early run in tracking
    f_before = int'(freq_o);
    repeat (16) early_cyc();
    quiet_cyc();
    chk(int'(freq_o) == m_freq && int'(freq_o) < f_before, "R5 track run",
        int'(freq_o), m_freq);

    // persistent early votes: floor and back to acquisition
    repeat (300) early_cyc();
    chk(freq_o == -5'sd16, "R9 floor", int'(freq_o), -16);
    chk(!track_o && !lock_o, "R6 R7 leave", int'({track_o, lock_o}), 0);

    // seeded random vectors
    for (int i = 0; i < 1200; i++) begin
      logic [NS-1:0] r;
      int sel = $urandom_range(0, 3);
      if (sel == 0) r = NS'($urandom);
      else if (sel == 1) r = mk(BITS'($urandom), 1'b0, mprev);
      else if (sel == 2) r = mk(BITS'($urandom), 1'b1, mprev);
      else r = {NS{mprev}};
      step(r);
    end
    chk(wrapped, "R10 wrap seen", int'(wrapped), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule